// File: doc/BRIEF.md
# Cycle-Steal Byte DMA Channel

This block is a single DMA channel that copies one byte per accepted request. For each request it raises a bus request and waits for the grant. It then runs one read cycle at the working source address and one write cycle at the working destination address, and releases the bus. A request comes either from a rising edge on one hardware request line, chosen by a select field, or from a software trigger bit in the control register.

The channel keeps working source, destination and count registers, and each one has a reload latch behind it. A mode register sets, for source and destination separately, whether the address holds, steps up by one or steps down by one after each byte. The count steps down after every byte. A transfer made while the count is zero is an underflow. On underflow the count always reloads from its latch. The addresses reload from their latches only when the reload-disable bit is clear. An underflow sets a sticky flag and an interrupt request, and can also clear the channel enable. Software can copy all three latches into the working registers at any time with a reload command.

Top module: `csdma_chan`

## Requirements
- R1: Each accepted request drives bus_req high until bus_gnt is seen. It then runs exactly one cycle with mem_rd high at the source address, followed by exactly one cycle with mem_wr high at the destination address, carrying the byte read. bus_req drops after the write cycle.
- R2: A rising edge on hw_req[sel] starts a transfer, where sel is mode bits [9:8]. Edges on the other lines do nothing, and a line held high starts only one transfer.
- R3: Writing a control word (address 4) with bit 0 set starts a transfer. Bit 0 always reads back as 0.
- R4: Source step is mode bits [1:0] and destination step is mode bits [3:2]. In each field, 01 adds 1 after a transfer, 10 subtracts 1 (both modulo 2^AW), and 00 or 11 hold the address.
- R5: The count (address 2) drops by 1 after each transfer. A transfer that starts with count 0 is an underflow, and it leaves the count equal to its latch value.
- R6: On underflow, the source and destination reload from their latches when reload-disable (mode bit 6) is 0. When that bit is 1, they keep their stepped values.
- R7: Underflow sets the underflow flag (control bit 2) and the interrupt request (control bit 3, also the irq port). Each stays set until software writes 0 to its own bit. Writing 1 to either bit has no effect.
- R8: When disable-after-underflow (mode bit 5) is 1, an underflow clears the enable bit (mode bit 4).
- R9: Writing a control word with bit 1 set copies the source, destination and count latches into the working registers in one cycle.
- R10: Requests are accepted only while the enable bit is 1. A request that arrives during a transfer causes exactly one further transfer after it.
- R11: A write to source (address 0), destination (address 1) or count (address 2) loads both the latch and the working register. Reads return the working values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| hw_req | input | NHW | Hardware request lines |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read strobe; data is taken in the same cycle |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Memory read data |
| mem_wdata | output | 8 | Memory write data |
| irq | output | 1 | Interrupt request |

## Verification
The main sweep covers every pair of source and destination step modes, once with reload-disable clear and once with it set. Each case runs four transfers from a count of 2, so it includes one underflow and one transfer after the reload. This separates the hold, increment and decrement codes, and it also separates address reload from address keep. Further patterns check the request paths: pulses on a line that is not selected, a line held high, triggers while the channel is disabled, a second trigger while a long grant wait is in progress, the disable-after-underflow mode, and an explicit reload command issued partway through a run.

// File: rtl/csdma_pkg.sv
package csdma_pkg;
  typedef enum logic [2:0] {
    RA_SRC  = 3'd0,
    RA_DST  = 3'd1,
    RA_CNT  = 3'd2,
    RA_MODE = 3'd3,
    RA_CTRL = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_RD,
    S_WR
  } seq_e;

  // mode register bit positions
  localparam int MB_SSTEP = 0;
  localparam int MB_DSTEP = 2;
  localparam int MB_EN    = 4;
  localparam int MB_DAU   = 5;
  localparam int MB_RLDIS = 6;
  localparam int MB_SEL   = 8;
  // control register bit positions
  localparam int CB_SWT   = 0;
  localparam int CB_RLD   = 1;
  localparam int CB_UF    = 2;
  localparam int CB_IRQ   = 3;
endpackage

// File: rtl/csdma_addr.sv
module csdma_addr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          rl,
  input  logic          stp,
  input  logic [1:0]    mode,
  output logic [AW-1:0] q
);
  logic [AW-1:0] lat_q, lat_d, q_d;

  always_comb begin
    lat_d = lat_q;
    q_d   = q;
    if (stp) begin
      case (mode)
        2'b01:   q_d = q + AW'(1);
        2'b10:   q_d = q - AW'(1);
        default: q_d = q;
      endcase
    end
    if (rl) q_d = lat_q;
    if (ld) begin
      lat_d = ld_val;
      q_d   = ld_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      q     <= '0;
    end else begin
      lat_q <= lat_d;
      q     <= q_d;
    end
  end
endmodule

// File: rtl/csdma_trig.sv
module csdma_trig #(
  parameter int NHW  = 4,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NHW-1:0]  hw_req,
  input  logic [SELW-1:0] sel,
  input  logic            en,
  input  logic            sw_fire,
  input  logic            take,
  output logic            pending
);
  logic line_now, prev_q, pend_d;

  assign line_now = hw_req[sel];

  always_comb begin
    pend_d = pending;
    if (take) pend_d = 1'b0;
    if (sw_fire || (line_now && !prev_q)) pend_d = 1'b1;
    if (!en) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pending <= 1'b0;
    end else begin
      prev_q  <= line_now;
      pending <= pend_d;
    end
  end
endmodule

// File: rtl/csdma_seq.sv
module csdma_seq
  import csdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic en,
  input  logic bus_gnt,
  output logic take,
  output logic bus_req,
  output logic rd_cyc,
  output logic wr_cyc
);
  seq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    take = 1'b0;
    case (st_q)
      S_IDLE: if (pending && en) begin
        st_d = S_REQ;
        take = 1'b1;
      end
      S_REQ:   if (bus_gnt) st_d = S_RD;
      S_RD:    st_d = S_WR;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign bus_req = (st_q != S_IDLE);
  assign rd_cyc  = (st_q == S_RD);
  assign wr_cyc  = (st_q == S_WR);
endmodule

// File: rtl/csdma_regs.sv
module csdma_regs
  import csdma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 8,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  input  logic            done,
  input  logic [AW-1:0]   src_q,
  input  logic [AW-1:0]   dst_q,
  output logic [1:0]      sstep,
  output logic [1:0]      dstep,
  output logic            en_q,
  output logic [SELW-1:0] sel_q,
  output logic            sw_fire,
  output logic            ld_src,
  output logic            ld_dst,
  output logic            rl_addr,
  output logic            uf_q,
  output logic            irq_q
);
  logic [CW-1:0]   cnt_q, cnt_d, cntl_q, cntl_d;
  logic [1:0]      sstep_d, dstep_d;
  logic            en_d, dau_q, dau_d, rldis_q, rldis_d, uf_d, irq_d;
  logic [SELW-1:0] sel_d;
  logic            wr_cnt, wr_mode, wr_ctrl, uf_evt, rld_cmd;

  assign wr_cnt  = reg_we && (reg_addr == RA_CNT);
  assign wr_mode = reg_we && (reg_addr == RA_MODE);
  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign ld_src  = reg_we && (reg_addr == RA_SRC);
  assign ld_dst  = reg_we && (reg_addr == RA_DST);
  assign sw_fire = wr_ctrl && reg_wdata[CB_SWT];
  assign rld_cmd = wr_ctrl && reg_wdata[CB_RLD];
  assign uf_evt  = done && (cnt_q == '0);
  assign rl_addr = rld_cmd || (uf_evt && !rldis_q);

  always_comb begin
    cnt_d   = cnt_q;
    cntl_d  = cntl_q;
    sstep_d = sstep;
    dstep_d = dstep;
    en_d    = en_q;
    dau_d   = dau_q;
    rldis_d = rldis_q;
    sel_d   = sel_q;
    uf_d    = uf_q;
    irq_d   = irq_q;
    if (done) cnt_d = uf_evt ? cntl_q : cnt_q - CW'(1);
    if (uf_evt) begin
      uf_d  = 1'b1;
      irq_d = 1'b1;
      if (dau_q) en_d = 1'b0;
    end
    if (rld_cmd) cnt_d = cntl_q;
    if (wr_cnt) begin
      cnt_d  = reg_wdata[CW-1:0];
      cntl_d = reg_wdata[CW-1:0];
    end
    if (wr_mode) begin
      sstep_d = reg_wdata[MB_SSTEP +: 2];
      dstep_d = reg_wdata[MB_DSTEP +: 2];
      en_d    = reg_wdata[MB_EN];
      dau_d   = reg_wdata[MB_DAU];
      rldis_d = reg_wdata[MB_RLDIS];
      sel_d   = reg_wdata[MB_SEL +: SELW];
    end
    if (wr_ctrl && !reg_wdata[CB_UF])  uf_d  = 1'b0;
    if (wr_ctrl && !reg_wdata[CB_IRQ]) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; cntl_q <= '0; sstep <= '0; dstep <= '0;
      en_q <= 1'b0; dau_q <= 1'b0; rldis_q <= 1'b0; sel_q <= '0;
      uf_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d; cntl_q <= cntl_d; sstep <= sstep_d; dstep <= dstep_d;
      en_q <= en_d; dau_q <= dau_d; rldis_q <= rldis_d; sel_q <= sel_d;
      uf_q <= uf_d; irq_q <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_SRC: reg_rdata = src_q;
      RA_DST: reg_rdata = dst_q;
      RA_CNT: reg_rdata = AW'(cnt_q);
      RA_MODE: begin
        reg_rdata[MB_SSTEP +: 2]    = sstep;
        reg_rdata[MB_DSTEP +: 2]    = dstep;
        reg_rdata[MB_EN]            = en_q;
        reg_rdata[MB_DAU]           = dau_q;
        reg_rdata[MB_RLDIS]         = rldis_q;
        reg_rdata[MB_SEL +: SELW]   = sel_q;
      end
      RA_CTRL: begin
        reg_rdata[CB_UF]  = uf_q;
        reg_rdata[CB_IRQ] = irq_q;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/csdma_chan.sv
module csdma_chan
  import csdma_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int NHW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [2:0]     reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata,
  input  logic [NHW-1:0] hw_req,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  input  logic [7:0]     mem_rdata,
  output logic [7:0]     mem_wdata,
  output logic           irq
);
  localparam int SELW = (NHW > 1) ? $clog2(NHW) : 1;

  logic [1:0]      rst_sync_q;
  logic            srst_n;
  logic [AW-1:0]   addr_w [2];
  logic [1:0]      step_w [2];
  logic            ld_w   [2];
  logic [1:0]      sstep, dstep;
  logic            en_q, uf_q, irq_q, sw_fire, ld_src, ld_dst, rl_addr;
  logic            pending, take, rd_cyc, wr_cyc, done;
  logic [SELW-1:0] sel_q;
  logic [7:0]      byte_q, byte_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  assign done      = wr_cyc;
  assign step_w[0] = sstep;
  assign step_w[1] = dstep;
  assign ld_w[0]   = ld_src;
  assign ld_w[1]   = ld_dst;

  // index 0 = source, index 1 = destination
  for (genvar gi = 0; gi < 2; gi++) begin : g_addr
    csdma_addr #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(srst_n), .ld(ld_w[gi]), .ld_val(reg_wdata),
      .rl(rl_addr), .stp(done), .mode(step_w[gi]), .q(addr_w[gi])
    );
  end

  csdma_regs #(.AW(AW), .CW(CW), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(srst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
    .src_q(addr_w[0]), .dst_q(addr_w[1]), .sstep(sstep), .dstep(dstep),
    .en_q(en_q), .sel_q(sel_q), .sw_fire(sw_fire), .ld_src(ld_src),
    .ld_dst(ld_dst), .rl_addr(rl_addr), .uf_q(uf_q), .irq_q(irq_q)
  );

  csdma_trig #(.NHW(NHW), .SELW(SELW)) u_trig (
    .clk(clk), .rst_n(srst_n), .hw_req(hw_req), .sel(sel_q), .en(en_q),
    .sw_fire(sw_fire), .take(take), .pending(pending)
  );

  csdma_seq u_seq (
    .clk(clk), .rst_n(srst_n), .pending(pending), .en(en_q),
    .bus_gnt(bus_gnt), .take(take), .bus_req(bus_req),
    .rd_cyc(rd_cyc), .wr_cyc(wr_cyc)
  );

  always_comb begin
    byte_d = byte_q;
    if (rd_cyc) byte_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) byte_q <= '0;
    else         byte_q <= byte_d;
  end

  assign mem_rd    = rd_cyc;
  assign mem_wr    = wr_cyc;
  assign mem_addr  = wr_cyc ? addr_w[1] : addr_w[0];
  assign mem_wdata = byte_q;
  assign irq       = irq_q;
endmodule

// File: rtl/csdma_chk.sv
module csdma_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [7:0] mem_rdata,
  input logic [7:0] mem_wdata,
  input logic       uf_flag,
  input logic       irq,
  input logic       chan_en
);
  AST_STROBE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (bus_req && bus_gnt));  // R1
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mem_wr && mem_wdata == $past(mem_rdata)));  // R1
  AST_ONE_WRITE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (!bus_req && !mem_wr));  // R1
  AST_UF_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uf_flag) |-> irq);  // R7
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(chan_en));  // R10
endmodule

bind csdma_chan csdma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
  .mem_wdata(mem_wdata), .uf_flag(uf_q), .irq(irq), .chan_en(en_q)
);

// File: tb/csdma_chan_tb.sv
module csdma_chan_tb;
  localparam int AW = 16;
  localparam int NHW = 4;
  localparam logic [2:0] A_SRC = 0, A_DST = 1, A_CNT = 2, A_MODE = 3, A_CTRL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic [NHW-1:0] hw_req = '0;
  logic bus_req, bus_gnt = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, irq;
  logic [7:0] mem_rdata, mem_wdata;
  logic [7:0] mem [256];
  int gdly = 0, gcnt = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  csdma_chan #(.AW(AW), .CW(8), .NHW(NHW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .irq(irq)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  always @(posedge clk) begin
    if (!bus_req) begin gcnt <= 0; bus_gnt <= 1'b0; end
    else if (gcnt >= gdly) bus_gnt <= 1'b1;
    else gcnt <= gcnt + 1;
  end

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] stepa(input logic [15:0] a, input int m);
    if (m == 1) return a + 16'd1;
    if (m == 2) return a - 16'd1;
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic xfer(output bit ran);
    ran = 1'b0;
    for (int i = 0; i < 12 && !ran; i++) begin @(negedge clk); if (bus_req) ran = 1'b1; end
    if (ran) for (int i = 0; i < 40 && bus_req; i++) @(negedge clk);
  endtask

  task automatic swtrig();  // control bit0 = trigger, keep flags (bits 2,3)
    wreg(A_CTRL, 16'h000D);
  endtask

  task automatic body();
    logic [15:0] v, es, ed;
    int ec;
    bit ran, exp_uf;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rreg(A_SRC, v);  chk(v == 0, "R11 reset src", v, 0);
    rreg(A_CNT, v);  chk(v == 0, "R11 reset count", v, 0);
    rreg(A_MODE, v); chk(v == 0, "R10 reset mode", v, 0);
    rreg(A_CTRL, v); chk(v == 0, "R7 reset flags", v, 0);
    chk(!bus_req && !irq, "R1 reset idle", {bus_req, irq}, 0);

    // R10: disabled channel ignores trigger
    wreg(A_CNT, 16'd9);
    swtrig(); xfer(ran);
    chk(!ran, "R10 no transfer when disabled", ran, 0);
    rreg(A_CNT, v); chk(v == 9, "R10 count untouched", v, 9);

    // main sweep over step modes and reload-disable
    for (int rd = 0; rd < 2; rd++)
      for (int sm = 0; sm < 4; sm++)
        for (int dm = 0; dm < 4; dm++) begin
          gdly = (sm + dm) % 3;
          wreg(A_SRC, 16'h0010); wreg(A_DST, 16'h0080); wreg(A_CNT, 16'd2);
          wreg(A_MODE, 16'(sm | (dm << 2) | (1 << 4) | (rd << 6)));
          wreg(A_CTRL, 16'h0000);
          es = 16'h0010; ed = 16'h0080; ec = 2;
          for (int k = 0; k < 4; k++) begin
            swtrig();
            rreg(A_CTRL, v); chk(v[0] == 1'b0, "R3 trigger bit reads 0", v, 0);
            xfer(ran);
            chk(ran, "R3 software trigger starts transfer", ran, 1);
            chk(mem[ed[7:0]] == pat(es), "R1 byte copied", mem[ed[7:0]], pat(es));
            exp_uf = (ec == 0);
            es = stepa(es, sm); ed = stepa(ed, dm);
            if (exp_uf) begin
              ec = 2;
              if (rd == 0) begin es = 16'h0010; ed = 16'h0080; end
            end else ec--;
            rreg(A_SRC, v); chk(v == es, exp_uf ? "R6 source after underflow" : "R4 source step", v, es);
            rreg(A_DST, v); chk(v == ed, exp_uf ? "R6 dest after underflow" : "R4 dest step", v, ed);
            rreg(A_CNT, v); chk(v == 16'(ec), "R5 count", v, ec);
            rreg(A_CTRL, v); chk(v[2] == exp_uf && v[3] == exp_uf, "R7 flag and irq", v, exp_uf ? 12 : 0);
            if (exp_uf) wreg(A_CTRL, 16'h0000);
          end
        end
    gdly = 0;

    // R2: hardware request select = 2
    wreg(A_CNT, 16'd20);
    wreg(A_MODE, 16'h0210);
    @(negedge clk); hw_req[1] = 1'b1; @(negedge clk); hw_req[1] = 1'b0;
    xfer(ran); chk(!ran, "R2 unselected line ignored", ran, 0);
    rreg(A_CNT, v); chk(v == 20, "R2 count after unselected pulse", v, 20);
    @(negedge clk); hw_req[2] = 1'b1;
    xfer(ran); chk(ran, "R2 selected edge starts", ran, 1);
    repeat (20) @(negedge clk);
    rreg(A_CNT, v); chk(v == 19, "R2 held line one transfer", v, 19);
    @(negedge clk); hw_req[2] = 1'b0; @(negedge clk); hw_req[2] = 1'b1;
    xfer(ran); @(negedge clk); hw_req[2] = 1'b0;
    rreg(A_CNT, v); chk(v == 18, "R2 second edge", v, 18);

    // R10: request during transfer kept pending
    gdly = 6;
    wreg(A_CNT, 16'd5); wreg(A_MODE, 16'h0015);
    swtrig();
    for (int i = 0; i < 12 && !bus_req; i++) @(negedge clk);
    swtrig();
    chk(bus_req, "R10 second trigger inside transfer", bus_req, 1);
    for (int i = 0; i < 40 && bus_req; i++) @(negedge clk);
    xfer(ran); chk(ran, "R10 pending request served", ran, 1);
    repeat (15) @(negedge clk);
    rreg(A_CNT, v); chk(v == 3, "R10 exactly two transfers", v, 3);
    gdly = 0;

    // R9: reload command
    wreg(A_SRC, 16'h0020); wreg(A_DST, 16'h0090); wreg(A_CNT, 16'd7);
    rreg(A_DST, v); chk(v == 16'h0090, "R11 write readback", v, 16'h0090);
    swtrig(); xfer(ran); swtrig(); xfer(ran);
    rreg(A_SRC, v); chk(v == 16'h0022, "R4 source +2", v, 16'h0022);
    wreg(A_CTRL, 16'h000E);
    rreg(A_SRC, v); chk(v == 16'h0020, "R9 source reload", v, 16'h0020);
    rreg(A_DST, v); chk(v == 16'h0090, "R9 dest reload", v, 16'h0090);
    rreg(A_CNT, v); chk(v == 7, "R9 count reload", v, 7);

    // R8 and R7: disable after underflow, flag clearing
    wreg(A_CNT, 16'd0); wreg(A_MODE, 16'h0030); wreg(A_CTRL, 16'h0000);
    swtrig(); xfer(ran);
    rreg(A_MODE, v); chk(v[4] == 1'b0, "R8 enable cleared", v, 16'h0020);
    chk(irq, "R7 irq port set", irq, 1);
    swtrig(); xfer(ran); chk(!ran, "R8 no transfer after disable", ran, 0);
    wreg(A_CTRL, 16'h0004);
    rreg(A_CTRL, v); chk(v == 16'h0004 && !irq, "R7 irq cleared, flag kept", v, 4);
    wreg(A_CTRL, 16'h0008);
    rreg(A_CTRL, v); chk(v == 0, "R7 flag cleared, writing 1 to irq has no effect", v, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(16'(i));
    fork
      body();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule